// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This unit resolves hazards for a five-stage in-order integer pipeline. The stages, in order, are fetch, decode with register read, ALU with branch resolution, memory access and writeback. Each cycle the pipeline registers supply the unit with the decode-stage source register numbers, the destination, write-enable and valid bits of the ALU-stage and memory-stage instructions, a load flag for the ALU-stage instruction and a taken indication for a branch resolved in the ALU stage. The unit drives three kinds of output: operand-source selects for the instruction in decode, a stall, and a flush for the two youngest stages.

All outputs are combinational from the current stage contents. The datapath latches the operand selects into the decode/ALU pipeline register together with the decode instruction, so they steer the ALU input muxes in the following cycle. A taken branch kills the fetch and decode slots, and the datapath then fetches the target in the next cycle. A load followed at once by a consumer of its result holds fetch and decode for one cycle and sends a bubble into the ALU stage. The load value then reaches the consumer through the memory-stage bypass. Write-after-write and write-after-read orderings need no action, because every write happens in order in writeback. The register file writes in the first half of a cycle and reads in the second half, so a producer that is in writeback needs no bypass either.

Top module: `hazard_ctrl`

## Requirements
- R1: When the decode instruction reads a nonzero register written by a valid, write-enabled, non-load ALU-stage instruction, the operand select for that source is 1 (ALU-result bypass), and stall_o stays low.
- R2: When the decode instruction reads a nonzero register written by a valid, write-enabled memory-stage instruction and the ALU stage does not supply it, the operand select is 2 (memory-stage bypass, which also carries load data).
- R3: When both the ALU-stage and the memory-stage producers match a source, the younger one wins and the select is 1.
- R4: When the decode instruction reads the destination of a valid, write-enabled load in the ALU stage, stall_o is high for exactly one cycle. In the next cycle the same source selects 2.
- R5: Register 0 never produces a bypass select or a stall, whether it appears as a source or as a destination.
- R6: Producers that are invalid or have write enable low are ignored for both bypass and stall.
- R7: A producer that has reached writeback gives no bypass. The select is 0 (register file) when neither younger stage matches.
- R8: A valid taken branch in the ALU stage raises flush_if_o and flush_id_o in that cycle. A taken flag on an invalid ALU stage raises neither.
- R9: A flush overrides a stall in the same cycle: stall_o is low whenever the flush outputs are high.
- R10: With the decode stage invalid, stall_o is low and both selects are 0.
- R11: Ten hazard-free instructions retire in 14 cycles. Each load-use pair adds exactly one cycle, and a taken branch costs two cycles.
- R12: A load in the ALU stage whose destination matches no decode source causes no stall, even when the decode instruction overwrites or previously read that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (used by checks only) |
| rst_ni | input | 1 | Active-low asynchronous reset (used by checks only) |
| id_valid_i | input | 1 | Decode stage holds an instruction |
| id_src_i | input | 2x5 | Decode source registers, [0] first operand, [1] second |
| ex_valid_i | input | 1 | ALU stage holds an instruction |
| ex_rd_i | input | 5 | ALU-stage destination register |
| ex_we_i | input | 1 | ALU-stage instruction writes a register |
| ex_load_i | input | 1 | ALU-stage instruction is a load |
| ex_taken_i | input | 1 | ALU-stage branch or jump is taken |
| mem_valid_i | input | 1 | Memory stage holds an instruction |
| mem_rd_i | input | 5 | Memory-stage destination register |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| fwd_sel_o | output | 2x2 | Per-operand source: 0 register file, 1 ALU-result bypass, 2 memory-stage bypass |
| stall_o | output | 1 | Hold fetch and decode, bubble into the ALU stage |
| flush_if_o | output | 1 | Kill the fetch-stage instruction |
| flush_id_o | output | 1 | Kill the decode-stage instruction |

## Verification
The hardest case to reach is a flush and a load-use stall requested in the same cycle. A consistent program never puts a load and a taken branch in the ALU stage together. The bench therefore runs a synthetic instruction that carries both flags, followed by a reader of its destination. Bubbles drive the destination and source fields of a valid-looking, write-enabled, taken load onto the ports. This tests that invalid producers and invalid decode slots are ignored without any special stimulus. Cycle counts for whole programs are taken from a behavioural pipeline around the unit.

// File: rtl/haz_pkg.sv
package haz_pkg;
  typedef enum logic [1:0] {
    SRC_RF      = 2'd0,
    SRC_ALU_BYP = 2'd1,
    SRC_MEM_BYP = 2'd2
  } opnd_src_e;
endpackage

// File: rtl/haz_opnd_sel.sv
module haz_opnd_sel #(
  parameter int REG_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                id_valid_i,
  input  logic [REG_W-1:0]    src_i,
  input  logic                ex_byp_i,
  input  logic [REG_W-1:0]    ex_rd_i,
  input  logic                mem_wr_i,
  input  logic [REG_W-1:0]    mem_rd_i,
  output haz_pkg::opnd_src_e  sel_o
);
  logic live;
  assign live = id_valid_i && (src_i != '0);

  always_comb begin
    sel_o = haz_pkg::SRC_RF;
    if (live) begin
      if (ex_byp_i && (ex_rd_i == src_i))        sel_o = haz_pkg::SRC_ALU_BYP;
      else if (mem_wr_i && (mem_rd_i == src_i))  sel_o = haz_pkg::SRC_MEM_BYP;
    end
  end

  // R5
  zero_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (sel_o == haz_pkg::SRC_RF));
  // R3
  youngest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && ex_byp_i && mem_wr_i && ex_rd_i == src_i && mem_rd_i == src_i)
      |-> (sel_o == haz_pkg::SRC_ALU_BYP));
endmodule

// File: rtl/haz_load_use.sv
module haz_load_use #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            id_valid_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   id_src_i,
  input  logic                            ex_ld_wr_i,
  input  logic [REG_W-1:0]                ex_rd_i,
  input  logic                            redirect_i,
  output logic                            stall_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
    assign hit[g] = ex_ld_wr_i && (ex_rd_i == id_src_i[g]);
  end

  // wrong-path consumer must not hold the pipe
  assign stall_o = id_valid_i && (|hit) && !redirect_i;

  // R9
  flush_over_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> !stall_o);
  // R4: the stall bubbles the load's successor slot, so it cannot repeat
  single_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
  // R6
  stall_needs_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ex_ld_wr_i);
endmodule

// File: rtl/haz_redirect.sv
module haz_redirect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ex_valid_i,
  input  logic ex_taken_i,
  output logic redirect_o,
  output logic flush_if_o,
  output logic flush_id_o
);
  assign redirect_o = ex_valid_i && ex_taken_i;
  assign flush_if_o = redirect_o;
  assign flush_id_o = redirect_o;

  // R8
  bubble_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_valid_i |-> (!flush_if_o && !flush_id_o));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            id_valid_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   id_src_i,
  input  logic                            ex_valid_i,
  input  logic [REG_W-1:0]                ex_rd_i,
  input  logic                            ex_we_i,
  input  logic                            ex_load_i,
  input  logic                            ex_taken_i,
  input  logic                            mem_valid_i,
  input  logic [REG_W-1:0]                mem_rd_i,
  input  logic                            mem_we_i,
  output logic [NUM_SRC-1:0][1:0]         fwd_sel_o,
  output logic                            stall_o,
  output logic                            flush_if_o,
  output logic                            flush_id_o
);
  logic ex_wr, mem_wr, ex_byp, ex_ld_wr, redirect;

  // r0 writes are architecturally void
  assign ex_wr    = ex_valid_i && ex_we_i && (ex_rd_i != '0);
  assign mem_wr   = mem_valid_i && mem_we_i && (mem_rd_i != '0);
  assign ex_byp   = ex_wr && !ex_load_i;
  assign ex_ld_wr = ex_wr && ex_load_i;

  haz_redirect u_redirect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ex_valid_i (ex_valid_i),
    .ex_taken_i (ex_taken_i),
    .redirect_o (redirect),
    .flush_if_o (flush_if_o),
    .flush_id_o (flush_id_o)
  );

  haz_load_use #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_load_use (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .id_valid_i (id_valid_i),
    .id_src_i   (id_src_i),
    .ex_ld_wr_i (ex_ld_wr),
    .ex_rd_i    (ex_rd_i),
    .redirect_i (redirect),
    .stall_o    (stall_o)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    haz_pkg::opnd_src_e sel;
    haz_opnd_sel #(.REG_W(REG_W)) u_sel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .id_valid_i (id_valid_i),
      .src_i      (id_src_i[g]),
      .ex_byp_i   (ex_byp),
      .ex_rd_i    (ex_rd_i),
      .mem_wr_i   (mem_wr),
      .mem_rd_i   (mem_rd_i),
      .sel_o      (sel)
    );
    assign fwd_sel_o[g] = sel;
  end

  // R10
  idle_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |-> (!stall_o && fwd_sel_o == '0));
  // R8
  taken_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && ex_taken_i) |-> (flush_if_o && flush_id_o && !stall_o));
  // R1
  alu_byp_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && !ex_load_i) |-> !stall_o);
endmodule

// File: tb/hazard_ctrl_tb.sv
`timescale 1ns/1ps
module hazard_ctrl_tb;
  typedef struct packed {
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic       we;
    logic       ld;
    logic       br;
    logic [4:0] tgt;
  } ins_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic id_valid, ex_valid, ex_we, ex_load, ex_taken, mem_valid, mem_we;
  logic [1:0][4:0] id_src;
  logic [4:0] ex_rd, mem_rd;
  logic [1:0][1:0] fwd_sel;
  logic stall, flush_if, flush_id;

  int checks = 0, fails = 0;
  ins_t prog [16];
  int   plen;
  int   st [5];
  // bubbles present a write-enabled taken load on r9 to the ports
  localparam ins_t GHOST = '{rd: 5'd9, rs1: 5'd9, rs2: 5'd9, we: 1'b1, ld: 1'b1, br: 1'b1, tgt: 5'd0};

  always #2 clk = ~clk;

  hazard_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .id_valid_i(id_valid), .id_src_i(id_src),
    .ex_valid_i(ex_valid), .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_load),
    .ex_taken_i(ex_taken), .mem_valid_i(mem_valid), .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .fwd_sel_o(fwd_sel), .stall_o(stall), .flush_if_o(flush_if), .flush_id_o(flush_id)
  );

  function automatic ins_t fld(int s);
    return (s < 0) ? GHOST : prog[s];
  endfunction

  task automatic chk(string tag, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp_v);
    end
  endtask

  task automatic set_ins(int i, int rd, int rs1, int rs2, bit we, bit ld, bit br, int tgt);
    prog[i] = '{rd: 5'(rd), rs1: 5'(rs1), rs2: 5'(rs2), we: we, ld: ld, br: br, tgt: 5'(tgt)};
  endtask

  task automatic fill_plain();
    plen = 10;
    for (int i = 0; i < 16; i++) set_ins(i, 1 + i, 20, 21, 1, 0, 0, 0);
  endtask

  task automatic drive();
    ins_t d, e, m;
    d = fld(st[1]); e = fld(st[2]); m = fld(st[3]);
    id_valid  = st[1] >= 0; id_src[0] = d.rs1; id_src[1] = d.rs2;
    ex_valid  = st[2] >= 0; ex_rd = e.rd; ex_we = e.we; ex_load = e.ld; ex_taken = e.br;
    mem_valid = st[3] >= 0; mem_rd = m.rd; mem_we = m.we;
  endtask

  task automatic run_prog(string tag, int exp_cyc, int exp_ret);
    int cyc = 0, ret = 0, pc = 1;
    st[0] = 0; st[1] = -1; st[2] = -1; st[3] = -1; st[4] = -1;
    while (ret < exp_ret && cyc < 100) begin
      ins_t d, e, m;
      bit e_ok, m_ok, fl, stl;
      int sel, s;
      @(negedge clk);
      drive();
      #1;
      d = fld(st[1]); e = fld(st[2]); m = fld(st[3]);
      e_ok = (st[2] >= 0) && e.we && (e.rd != 0);
      m_ok = (st[3] >= 0) && m.we && (m.rd != 0);
      fl   = (st[2] >= 0) && e.br;
      stl  = !fl && (st[1] >= 0) && e_ok && e.ld && ((d.rs1 == e.rd) || (d.rs2 == e.rd));
      chk({tag, " R8 flush_if"}, int'(flush_if), int'(fl));
      chk({tag, " R8 flush_id"}, int'(flush_id), int'(fl));
      chk({tag, " R4/R9 stall"}, int'(stall), int'(stl));
      for (int k = 0; k < 2; k++) begin
        s = (k == 0) ? int'(d.rs1) : int'(d.rs2);
        if (st[1] < 0 || s == 0) sel = 0;
        else if (e_ok && !e.ld && int'(e.rd) == s) sel = 1;
        else if (m_ok && int'(m.rd) == s) sel = 2;
        else sel = 0;
        chk({tag, " R1/R2 select"}, int'(fwd_sel[k]), sel);
      end
      cyc++;
      if (st[4] >= 0) ret++;
      st[4] = st[3]; st[3] = st[2];
      if (fl) begin
        st[2] = -1; st[1] = -1; st[0] = int'(e.tgt); pc = int'(e.tgt) + 1;
      end else if (stl) begin
        st[2] = -1;
      end else begin
        st[2] = st[1]; st[1] = st[0];
        st[0] = (pc < plen) ? pc : -1;
        if (pc < plen) pc++;
      end
    end
    chk({tag, " R11 cycles"}, cyc, exp_cyc);
    chk({tag, " R11 retired"}, ret, exp_ret);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    id_valid = 0; ex_valid = 0; mem_valid = 0; id_src = '0; ex_rd = 0; mem_rd = 0;
    ex_we = 0; ex_load = 0; ex_taken = 0; mem_we = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset stall", int'(stall), 0);
    chk("R10 reset select", int'(fwd_sel), 0);
    chk("R8 reset flush", int'(flush_if | flush_id), 0);
    rst_n = 1'b1;

    // R11: independent stream
    fill_plain();
    run_prog("R11 plain", 14, 10);

    // R1 R2 R3 R7: bypass ordering
    fill_plain();
    set_ins(0, 1, 20, 21, 1, 0, 0, 0);
    set_ins(1, 1, 2, 20, 1, 0, 0, 0);
    set_ins(2, 3, 1, 1, 1, 0, 0, 0);
    set_ins(3, 4, 1, 20, 1, 0, 0, 0);
    set_ins(4, 5, 20, 1, 1, 0, 0, 0);
    set_ins(5, 6, 3, 4, 1, 0, 0, 0);
    run_prog("R1 R2 R3 R7 bypass", 14, 10);

    // R4 R12: load-use and harmless load orderings
    fill_plain();
    set_ins(0, 5, 20, 21, 1, 1, 0, 0);
    set_ins(1, 7, 5, 20, 1, 0, 0, 0);
    set_ins(3, 8, 20, 21, 1, 1, 0, 0);
    set_ins(4, 10, 20, 8, 1, 0, 0, 0);
    set_ins(6, 12, 20, 21, 1, 1, 0, 0);
    set_ins(7, 12, 20, 21, 1, 0, 0, 0);
    set_ins(8, 13, 1, 21, 1, 1, 0, 0);
    set_ins(9, 1, 20, 21, 1, 0, 0, 0);
    run_prog("R4 R12 load-use", 16, 10);

    // R5 R6: register 0 and non-writing producers
    fill_plain();
    set_ins(0, 0, 20, 21, 1, 0, 0, 0);
    set_ins(1, 2, 0, 0, 1, 0, 0, 0);
    set_ins(2, 0, 20, 21, 1, 1, 0, 0);
    set_ins(3, 3, 0, 20, 1, 0, 0, 0);
    set_ins(4, 4, 20, 21, 0, 1, 0, 0);
    set_ins(5, 6, 4, 4, 1, 0, 0, 0);
    set_ins(6, 6, 4, 20, 1, 0, 0, 0);
    run_prog("R5 R6 ignore", 14, 10);

    // R8: taken branch at 2 to 5
    fill_plain();
    set_ins(2, 0, 1, 2, 0, 0, 1, 5);
    set_ins(3, 9, 9, 9, 1, 1, 0, 0);
    run_prog("R8 branch", 14, 8);

    // R9 R6 R10: taken load-jump with a dependent reader in decode
    fill_plain();
    set_ins(0, 4, 20, 21, 1, 1, 1, 3);
    set_ins(1, 7, 4, 4, 1, 0, 0, 0);
    set_ins(3, 8, 9, 20, 1, 0, 0, 0);
    set_ins(4, 11, 20, 9, 1, 0, 0, 0);
    run_prog("R9 R6 R10 flush-over-stall", 14, 8);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule